// File: doc/BRIEF.md
# Digit-Serial Gaussian Normal Basis Field Multiplier

This block multiplies two elements of GF(2^M) given in normal-basis coordinates, for fields that have a Gaussian normal basis of type T. The ring size is P = M*T+1, which must be prime; this is checked while the design is built. On an accepted start, both operands are spread into P-bit vectors over the powers of a primitive P-th root of unity. Normal coordinate i lands on every ring position 2^i*u^j mod P, where u has multiplicative order T, and position 0 is zero.

The product is then formed in the cyclic ring modulo x^P+1. The multiplier operand is cut into N = ceil(P/D) digits of D bits, and the least significant digit is used first. Each round multiplies the current rotated copy of the first operand by one digit. The partial product is folded into an accumulator one D-bit slice per cycle, wrapping around modulo x^P+1. Between rounds the first operand is rotated up by D positions. When the last round ends, the accumulator is read back into M normal coordinates: coordinate i is ring position 2^i mod P, XORed with the ring's constant term, because the constant 1 equals the sum of all nonzero powers.

A single start input launches a multiply. A one-cycle done pulse marks a new result, and that result stays on its port until the next done.

Top module: `gnb_lsd_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy and done are 0 and result is all zeros.
- R2: For every pair of operands, result equals their GF(2^M) normal-basis product. Bit i of each operand and of result is the coefficient of the basis element β^(2^i).
- R3: done rises exactly LAT = D + N*(N+1) clock edges after the edge that accepts start, with N = ceil((M*T+1)/D). This is 14 for M=4, T=1, D=2.
- R4: done is high for exactly one cycle, and result changes only at the edge that raises done.
- R5: A start seen while busy is 1 is ignored. The operation in progress keeps its latency, and its result is that of the operands captured at acceptance.
- R6: Multiplying by the all-ones operand (the field's unity) returns the other operand, and multiplying by zero returns zero.
- R7: busy is 1 from the edge that accepts start until the edge that raises done, and it falls in the same edge that raises done.
- R8: A start presented in the cycle where done is 1 is accepted: busy is 1 and done is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a multiply (taken when busy is 0) |
| op_a | input | M | First operand, normal-basis coordinates |
| op_b | input | M | Second operand, normal-basis coordinates |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse: result is new |
| result | output | M | Product, normal-basis coordinates |

## Verification
The completion of one multiply and the acceptance of the next can fall in the same cycle. The bench drives every new start in the very cycle where done is high. It judges that the finished result is the expected product, that busy rises at once, and that the earlier result stays on the port until the next done. A second overlap is a start pulse arriving during a run: some operand pairs get a start with inverted operands partway through. Such a run must still finish after exactly LAT edges with the product of the originally captured operands.

// File: rtl/gnb_pkg.sv
package gnb_pkg;

   // (base^e) mod p by repeated multiplication
   function automatic int pow_mod(input int base, input int e, input int p);
      int r;
      r = 1 % p;
      for (int k = 0; k < e; k++) r = (r * base) % p;
      return r;
   endfunction

   function automatic bit is_prime(input int p);
      if (p < 2) return 1'b0;
      for (int k = 2; k * k <= p; k++) begin
         if (p % k == 0) return 1'b0;
      end
      return 1'b1;
   endfunction

   // multiplicative order of u modulo p, 0 if none below p
   function automatic int order_of(input int u, input int p);
      int r;
      r = u % p;
      for (int k = 1; k < p; k++) begin
         if (r == 1) return k;
         r = (r * u) % p;
      end
      return 0;
   endfunction

   // smallest element of order t modulo p
   function automatic int twist_root(input int t, input int p);
      for (int u = 1; u < p; u++) begin
         if (order_of(u, p) == t) return u;
      end
      return 0;
   endfunction

   // normal coordinate that owns ring position pos, -1 when none
   function automatic int coord_at(input int m, input int t, input int p, input int pos);
      int u;
      int pw2;
      int v;
      u   = twist_root(t, p);
      pw2 = 1;
      for (int i = 0; i < m; i++) begin
         v = pw2;
         for (int j = 0; j < t; j++) begin
            if (v == pos) return i;
            v = (v * u) % p;
         end
         pw2 = (pw2 * 2) % p;
      end
      return -1;
   endfunction

endpackage

// File: rtl/gnb_expand.sv
module gnb_expand #(
   parameter int M = 4,
   parameter int T = 1,
   parameter int P = 5
) (
   input  logic [M-1:0] nb,
   output logic [P-1:0] ring
);
   assign ring[0] = 1'b0;

   for (genvar k = 1; k < P; k++) begin : g_pos
      localparam int CI = gnb_pkg::coord_at(M, T, P, k);
      if (CI < 0 || CI >= M) begin : g_bad
         $error("ring position %0d has no normal coordinate; no basis of type %0d", k, T);
         assign ring[k] = 1'b0;
      end else begin : g_ok
         assign ring[k] = nb[CI];
      end
   end
endmodule

// File: rtl/gnb_compress.sv
module gnb_compress #(
   parameter int M = 4,
   parameter int P = 5
) (
   input  logic [P-1:0] ring,
   output logic [M-1:0] nb
);
   // constant term stands for the sum of all nonzero powers
   for (genvar i = 0; i < M; i++) begin : g_coord
      localparam int PI = gnb_pkg::pow_mod(2, i, P);
      assign nb[i] = ring[PI] ^ ring[0];
   end
endmodule

// File: rtl/gnb_digit_mac.sv
module gnb_digit_mac #(
   parameter int P  = 5,
   parameter int D  = 2,
   parameter int CW = 2
) (
   input  logic [P-1:0]  a_vec,
   input  logic [D-1:0]  b_dig,
   input  logic [CW-1:0] chunk,
   input  logic [P-1:0]  acc,
   output logic [P-1:0]  acc_nx
);
   localparam int XW = P + D - 1;
   localparam logic [XW-1:0] DIGIT_ONES = XW'({D{1'b1}});

   logic [XW-1:0] prod;
   logic [XW-1:0] slice_mask;
   logic [XW-1:0] sel;

   // Hankel-style product of the rotated operand with one digit
   always_comb begin
      prod = '0;
      for (int l = 0; l < P; l++) begin
         for (int j = 0; j < D; j++) begin
            prod[l+j] = prod[l+j] ^ (a_vec[l] & b_dig[j]);
         end
      end
   end

   assign slice_mask = DIGIT_ONES << (int'(chunk) * D);
   assign sel        = prod & slice_mask;

   if (D > 1) begin : g_fold
      // positions at and above P wrap around modulo x^P+1
      assign acc_nx = acc ^ sel[P-1:0] ^ P'(sel[XW-1:P]);
   end else begin : g_nofold
      assign acc_nx = acc ^ sel[P-1:0];
   end
endmodule

// File: rtl/gnb_seq.sv
module gnb_seq #(
   parameter int D  = 2,
   parameter int N  = 3,
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          load,
   output logic          acc_en,
   output logic [CW-1:0] chunk,
   output logic          round_end,
   output logic          finish
);
   localparam int CYW = $clog2(D + N + 2);
   localparam int RW  = $clog2(N + 1);
   localparam logic [CYW-1:0] FILL       = CYW'(D);
   localparam logic [CW-1:0]  LAST_CHUNK = CW'(N);
   localparam logic [RW-1:0]  LAST_RND   = RW'(N - 1);

   logic           busy_q;
   logic [RW-1:0]  rnd_q;
   logic [CYW-1:0] cyc_q;
   logic           in_fill;

   // the first round spends D cycles filling the array before slices land
   assign in_fill   = (rnd_q == '0) && (cyc_q < FILL);
   assign chunk     = (rnd_q == '0) ? CW'(cyc_q - FILL) : CW'(cyc_q);
   assign load      = start & ~busy_q;
   assign acc_en    = busy_q & ~in_fill;
   assign round_end = acc_en & (chunk == LAST_CHUNK);
   assign finish    = round_end & (rnd_q == LAST_RND);
   assign busy      = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rnd_q  <= '0;
         cyc_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         rnd_q  <= '0;
         cyc_q  <= '0;
      end else if (busy_q) begin
         if (round_end) begin
            cyc_q <= '0;
            if (finish) begin
               busy_q <= 1'b0;
               rnd_q  <= '0;
            end else begin
               rnd_q <= rnd_q + 1'b1;
            end
         end else begin
            cyc_q <= cyc_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/gnb_lsd_mul.sv
module gnb_lsd_mul #(
   parameter int M = 4,
   parameter int T = 1,
   parameter int D = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] op_a,
   input  logic [M-1:0] op_b,
   output logic         busy,
   output logic         done,
   output logic [M-1:0] result
);
   localparam int P   = M * T + 1;
   localparam int N   = (P + D - 1) / D;
   localparam int BW  = N * D;
   localparam int CW  = $clog2(N + 1);
   localparam int LAT = D + N * (N + 1);

   if (M < 2) begin : g_chk_m
      $error("M must be at least 2");
   end
   if (T < 1) begin : g_chk_t
      $error("T must be at least 1");
   end
   if (!gnb_pkg::is_prime(P)) begin : g_chk_p
      $error("M*T+1 = %0d is not prime", P);
   end
   if (D < 1 || D > P) begin : g_chk_d
      $error("digit size D must lie in 1..%0d", P);
   end

   logic [P-1:0]  a_exp, b_exp;
   logic [P-1:0]  a_q, a_rot, acc_q, acc_nx;
   logic [BW-1:0] b_q;
   logic [M-1:0]  res_nb, res_q;
   logic          done_q;
   logic          load, acc_en, round_end, finish;
   logic [CW-1:0] chunk;

   gnb_expand #(.M(M), .T(T), .P(P)) u_exp_a (.nb(op_a), .ring(a_exp));
   gnb_expand #(.M(M), .T(T), .P(P)) u_exp_b (.nb(op_b), .ring(b_exp));

   gnb_seq #(.D(D), .N(N), .CW(CW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .busy      (busy),
      .load      (load),
      .acc_en    (acc_en),
      .chunk     (chunk),
      .round_end (round_end),
      .finish    (finish)
   );

   gnb_digit_mac #(.P(P), .D(D), .CW(CW)) u_mac (
      .a_vec  (a_q),
      .b_dig  (b_q[D-1:0]),
      .chunk  (chunk),
      .acc    (acc_q),
      .acc_nx (acc_nx)
   );

   gnb_compress #(.M(M), .P(P)) u_cmp (.ring(acc_nx), .nb(res_nb));

   // multiply by x^D modulo x^P+1: cyclic move of every position up by D
   always_comb begin
      a_rot = '0;
      for (int l = 0; l < P; l++) a_rot[(l + D) % P] = a_q[l];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         acc_q  <= '0;
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= finish;
         if (load) begin
            a_q   <= a_exp;
            b_q   <= BW'(b_exp);
            acc_q <= '0;
         end else begin
            if (acc_en) acc_q <= acc_nx;
            if (round_end) begin
               a_q <= a_rot;
               b_q <= b_q >> D;
            end
         end
         if (finish) res_q <= res_nb;
      end
   end

   assign done   = done_q;
   assign result = res_q;
endmodule

// File: rtl/gnb_lsd_mul_chk.sv
module gnb_lsd_mul_chk #(
   parameter int M   = 4,
   parameter int LAT = 14
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic [M-1:0] result
);
   logic [31:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_cnt <= '0;
      else if (start && !busy) run_cnt <= '0;
      else if (busy)           run_cnt <= run_cnt + 32'd1;
   end

   // R3
   latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == LAT));

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

   // R5
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> (run_cnt == $past(run_cnt) + 32'd1));

   // R7
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R8
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));
endmodule

bind gnb_lsd_mul gnb_lsd_mul_chk #(.M(M), .LAT(LAT)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .result (result)
);

// File: tb/gnb_lsd_mul_bench.sv
module gnb_lsd_mul_bench;
   localparam int CLK_PERIOD = 10;
   localparam int M   = 4;
   localparam int T   = 1;
   localparam int D   = 2;
   localparam int P   = M * T + 1;
   localparam int N   = (P + D - 1) / D;
   localparam int LAT = D + N * (N + 1);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [M-1:0] op_a = '0;
   logic [M-1:0] op_b = '0;
   logic         busy, done;
   logic [M-1:0] result;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   gnb_lsd_mul #(.M(M), .T(T), .D(D)) u_gnb_lsd_mul (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .op_a   (op_a),
      .op_b   (op_b),
      .busy   (busy),
      .done   (done),
      .result (result)
   );

   // GF(16) multiply in polynomial basis modulo x^4+x^3+x^2+x+1
   function automatic logic [3:0] pmul(input logic [3:0] x, input logic [3:0] y);
      logic [4:0] sh;
      logic [3:0] r;
      sh = {1'b0, x};
      r  = '0;
      for (int k = 0; k < 4; k++) begin
         if (y[k]) r = r ^ sh[3:0];
         sh = sh << 1;
         if (sh[4]) sh = sh ^ 5'h1F;
      end
      return r;
   endfunction

   // normal coordinates to polynomial basis, basis element i = x^(2^i)
   function automatic logic [3:0] nb2poly(input logic [3:0] v);
      logic [3:0] bas;
      logic [3:0] r;
      bas = 4'b0010;
      r   = '0;
      for (int i = 0; i < 4; i++) begin
         if (v[i]) r = r ^ bas;
         bas = pmul(bas, bas);
      end
      return r;
   endfunction

   function automatic logic [3:0] ref_mul(input logic [3:0] a, input logic [3:0] b);
      logic [3:0] pr;
      pr = pmul(nb2poly(a), nb2poly(b));
      for (int c = 0; c < 16; c++) begin
         if (nb2poly(4'(c)) == pr) return 4'(c);
      end
      return 4'h0;
   endfunction

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // call at a negedge; returns at the negedge where done is high
   task automatic run_op(input logic [3:0] a, input logic [3:0] b, input bit poke);
      logic [3:0] prev;
      logic [3:0] exp;
      int         cyc;
      bit         hold_bad;
      prev     = result;
      exp      = ref_mul(a, b);
      hold_bad = 1'b0;
      start = 1'b1;
      op_a  = a;
      op_b  = b;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1 && done === 1'b0, "R8 start accepted, busy up done low",
            int'({busy, done}), 2);
      cyc = 1;
      while (done !== 1'b1 && cyc <= LAT + 4) begin
         if (poke && cyc == 3) begin
            start = 1'b1;
            op_a  = ~a;
            op_b  = ~b;
         end else begin
            start = 1'b0;
         end
         if (result !== prev) hold_bad = 1'b1;
         if (busy !== 1'b1) hold_bad = 1'b1;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      check(cyc == LAT + 1, poke ? "R5 latency with start while busy" : "R3 latency",
            cyc - 1, LAT);
      check(!hold_bad, "R4/R7 result held and busy high during run", int'(hold_bad), 0);
      check(busy === 1'b0, "R7 busy falls with done", int'(busy), 0);
      check(result === exp, poke ? "R5 product of captured operands" : "R2 product",
            int'(result), int'(exp));
      if (a == 4'hF) check(result === b, "R6 unity times b", int'(result), int'(b));
      if (a == 4'h0) check(result === 4'h0, "R6 zero times b", int'(result), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && result === '0, "R1 reset state",
            int'({busy, done, result}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && result === '0, "R1 after reset",
            int'({busy, done, result}), 0);
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            run_op(4'(a), 4'(b), ((a + b) % 7) == 0);
         end
      end
      begin
         logic [3:0] last;
         last = result;
         @(negedge clk);
         check(done === 1'b0, "R4 done lasts one cycle", int'(done), 0);
         repeat (5) @(negedge clk);
         check(result === last && done === 1'b0 && busy === 1'b0,
               "R4 result stable while idle", int'(result), int'(last));
      end
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end
endmodule